// File: doc/BRIEF.md
# APB Reload Down-Counter Timer

This block is a 32-bit programmable interval timer that sits behind an APB slave port. Software programs a reload value, an initial count and a small control word; the counter then steps down by one on every qualified tick. When the count steps from one to zero, a sticky flag is raised if interrupts are enabled, and a single level interrupt line mirrors that flag until software clears it by writing a one. After reaching zero the counter rests there for one tick and then takes the reload value. With a reload of zero the counter stops at zero after the first expiry, which gives one-shot use.

A tick is one of three things, chosen by two control bits: every bus clock cycle, every bus clock cycle while a synchronized external input is high (gated mode), or each rising edge of that synchronized input (edge mode, which wins if both bits are set). The external input passes through a two-flop synchronizer before any use. A fixed block of twelve identification bytes sits at the top of the 4 KB window.

The counter is run by a four-state machine. OFF: the run bit is clear and the count is frozen. DOWN: the count is nonzero and decrements per tick; the tick that takes it from 1 to 0 is the expiry, and moves to ZERO when the reload is nonzero, otherwise to PARK. ZERO: the count is zero; the next tick loads the reload value and returns to DOWN. PARK: the count is zero with a zero reload; it stays here. Every register write to the control, count or reload word re-evaluates the state from the run bit, the count and the reload: run clear gives OFF, a nonzero count gives DOWN, a zero count with nonzero reload gives ZERO, and otherwise PARK. In a cycle where such a write lands, the write wins over any tick.

Top module: `apb_reload_timer`

## Requirements
- R1: After reset the control word, count, reload and interrupt flag all read zero, the interrupt output is low, PREADY reads 1 and PSLVERR reads 0.
- R2: The control word at offset 0x0 keeps only written bits [3:0] (bit 0 run, bit 1 gated mode, bit 2 edge mode, bit 3 interrupt enable); bits [31:4] read as zero.
- R3: With the run bit set and both mode bits clear, the count at offset 0x4 drops by exactly one per bus clock; with the run bit clear it does not change.
- R4: The flag at offset 0xC bit 0 is set on the 1-to-0 step only when the interrupt enable is set, and the interrupt output equals the flag.
- R5: After the 1-to-0 step the count reads zero for exactly one tick, then takes the reload value and keeps counting down.
- R6: With a zero reload the count stays at zero after expiry and no further flag is raised.
- R7: A write to the reload word (offset 0x8) loads the same value into the count at once; a nonzero value with the run bit set keeps counting from it, and with run clear the count stays put.
- R8: A nonzero write to the count while running restarts counting from that value; a zero write with a zero reload stops the count at zero; a zero write with a nonzero reload loads the reload on the next tick without raising the flag.
- R9: Writing 1 to bit 0 of offset 0xC clears the flag, writing 0 leaves it; if an expiry and a clearing write land in the same cycle the flag ends set.
- R10: Offsets 0xFD0 to 0xFFC return in word order the bytes 04,00,00,00,22,B8,1B,00,0D,F0,05,B1 and ignore writes.
- R11: Any other offset reads zero and a write to it changes no register.
- R12: In gated mode (bits 1 and 0 set, bit 2 clear) the count drops once per bus clock only while the synchronized input is high, that input trailing the pin by two clocks.
- R13: In edge mode (bits 2 and 0 set) the count drops once per rising edge of the synchronized input however long it stays high; edge mode takes precedence when bit 1 is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0 |
| ext_in | input | 1 | Asynchronous external gate or count input |
| irq | output | 1 | Level interrupt, equal to the sticky flag |

## Verification
Two events can fall in the same cycle here: the expiry step that sets the flag and a software write of one that clears it. The bench loads a count of three, waits two cycles and issues the clearing write so that it commits on the very clock edge of the 1-to-0 step; the flag and the interrupt line must both read set afterwards, and a later clearing write away from any expiry must bring them low. The same reasoning covers a count or reload write landing on a tick edge, where the written value must appear without a decrement.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Counter state machine
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_DOWN = 2'd1,
        ST_ZERO = 2'd2,
        ST_PARK = 2'd3
    } cnt_state_e;

    // Tick source
    typedef enum logic [1:0] {
        SRC_PCLK = 2'd0,
        SRC_GATE = 2'd1,
        SRC_EDGE = 2'd2
    } tick_src_e;

    // Control word, bit 0 is run
    typedef struct packed {
        logic irq_en;
        logic edge_sel;
        logic gate_sel;
        logic run;
    } ctrl_t;

    localparam int unsigned ID_WORDS = 12;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] b;
        unique case (idx)
            4'd0:    b = 8'h04;
            4'd1:    b = 8'h00;
            4'd2:    b = 8'h00;
            4'd3:    b = 8'h00;
            4'd4:    b = 8'h22;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h1B;
            4'd7:    b = 8'h00;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[LAST];
        end
    end

    always_comb begin
        level_o = chain_q[LAST];
        rise_o  = chain_q[LAST] & ~prev_q;
    end

    // R13: an edge yields a single-cycle pulse
    a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
    import tmr_pkg::*;
(
    input  logic run_i,
    input  logic gate_sel_i,
    input  logic edge_sel_i,
    input  logic ext_level_i,
    input  logic ext_rise_i,
    output logic tick_o
);
    tick_src_e src;

    always_comb begin
        if (edge_sel_i)      src = SRC_EDGE;
        else if (gate_sel_i) src = SRC_GATE;
        else                 src = SRC_PCLK;
    end

    always_comb begin
        unique case (src)
            SRC_PCLK: tick_o = run_i;
            SRC_GATE: tick_o = run_i & ext_level_i;
            SRC_EDGE: tick_o = run_i & ext_rise_i;
            default:  tick_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         ctrl_wr_i,
    input  logic         value_wr_i,
    input  logic         reload_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] reload_o,
    output logic         expire_o
);
    localparam logic [W-1:0] ONE = W'(1);

    cnt_state_e   st_q, st_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] rld_q, rld_d;
    logic         ld_any;

    assign ld_any = ctrl_wr_i | value_wr_i | reload_wr_i;

    function automatic cnt_state_e classify(input logic run,
                                            input logic [W-1:0] c,
                                            input logic [W-1:0] r);
        cnt_state_e s;
        if (!run)           s = ST_OFF;
        else if (c != '0)   s = ST_DOWN;
        else if (r != '0)   s = ST_ZERO;
        else                s = ST_PARK;
        return s;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
            rld_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            rld_q <= rld_d;
        end
    end

    // Next state: writes take priority over ticks
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        rld_d = rld_q;
        if (reload_wr_i) begin
            rld_d = wdata_i;
            cnt_d = wdata_i;
            st_d  = classify(run_i, wdata_i, wdata_i);
        end else if (value_wr_i) begin
            cnt_d = wdata_i;
            st_d  = classify(run_i, wdata_i, rld_q);
        end else if (ctrl_wr_i) begin
            st_d  = classify(run_i, cnt_q, rld_q);
        end else if (tick_i) begin
            unique case (st_q)
                ST_DOWN: begin
                    if (cnt_q == ONE) begin
                        cnt_d = '0;
                        st_d  = (rld_q != '0) ? ST_ZERO : ST_PARK;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                ST_ZERO: begin
                    cnt_d = rld_q;
                    st_d  = (rld_q != '0) ? ST_DOWN : ST_PARK;
                end
                ST_OFF:  st_d = ST_OFF;
                ST_PARK: st_d = ST_PARK;
                default: st_d = ST_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cnt_o    = cnt_q;
        reload_o = rld_q;
        expire_o = tick_i && !ld_any && (st_q == ST_DOWN) && (cnt_q == ONE);
    end

    // R3: a running count moves by at most one per cycle
    a_r3_step_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DOWN && !ld_any) |=>
            (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - ONE));

    // R3: a stopped count is frozen
    a_r3_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && !ld_any) |=> $stable(cnt_q));

    // R5: the tick after reaching zero loads the reload value
    a_r5_zero_then_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ZERO && tick_i && !ld_any) |=> (cnt_q == $past(rld_q)));

    // R6: a parked counter stays parked at zero
    a_r6_park_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PARK && !ld_any) |=> (cnt_q == '0 && st_q == ST_PARK));

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [3:0]        pwdata_lo,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic [DATA_W-1:0] rld_i,
    input  logic              expire_i,
    output ctrl_t             ctrl_o,
    output logic              run_o,
    output logic              ctrl_wr_o,
    output logic              value_wr_o,
    output logic              reload_wr_o,
    output logic [DATA_W-1:0] prdata_o,
    output logic              irq_o
);
    localparam int unsigned WORD_W  = ADDR_W - 2;
    localparam int unsigned ID_BASE = (1 << WORD_W) - ID_WORDS;

    ctrl_t             ctrl_q;
    logic              sts_q, sts_d;
    logic              wr_en, aligned, sts_clr;
    logic [WORD_W-1:0] word;
    logic              hit_ctrl, hit_val, hit_rld, hit_sts, hit_id;
    logic [3:0]        id_idx;

    always_comb begin
        wr_en    = psel & penable & pwrite;
        aligned  = (paddr[1:0] == 2'b00);
        word     = paddr[ADDR_W-1:2];
        hit_ctrl = aligned && (word == WORD_W'(0));
        hit_val  = aligned && (word == WORD_W'(1));
        hit_rld  = aligned && (word == WORD_W'(2));
        hit_sts  = aligned && (word == WORD_W'(3));
        hit_id   = aligned && (word >= WORD_W'(ID_BASE));
        id_idx   = 4'(word - WORD_W'(ID_BASE));
    end

    always_comb begin
        ctrl_wr_o   = wr_en & hit_ctrl;
        value_wr_o  = wr_en & hit_val;
        reload_wr_o = wr_en & hit_rld;
        sts_clr     = wr_en & hit_sts & pwdata_lo[0];
        run_o       = ctrl_wr_o ? pwdata_lo[0] : ctrl_q.run;
    end

    // Flag: a new expiry outranks a clearing write
    always_comb begin
        sts_d = sts_q;
        if (sts_clr)                      sts_d = 1'b0;
        if (expire_i && ctrl_q.irq_en)    sts_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sts_q  <= 1'b0;
        end else begin
            if (ctrl_wr_o) ctrl_q <= ctrl_t'(pwdata_lo);
            sts_q <= sts_d;
        end
    end

    always_comb begin
        if (hit_ctrl)      prdata_o = {{(DATA_W-4){1'b0}}, ctrl_q};
        else if (hit_val)  prdata_o = cnt_i;
        else if (hit_rld)  prdata_o = rld_i;
        else if (hit_sts)  prdata_o = {{(DATA_W-1){1'b0}}, sts_q};
        else if (hit_id)   prdata_o = DATA_W'(id_byte(id_idx));
        else               prdata_o = '0;
        ctrl_o = ctrl_q;
        irq_o  = sts_q;
    end

    // R9: writing zero to the flag word never clears the flag
    a_r9_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && wr_en && hit_sts && !pwdata_lo[0]) |=> sts_q);

endmodule

// File: rtl/apb_reload_timer.sv
module apb_reload_timer
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              ext_in,
    output logic              irq
);
    ctrl_t             ctrl;
    logic              run_next, ctrl_wr, value_wr, reload_wr;
    logic              ext_level, ext_rise, tick, expire;
    logic [DATA_W-1:0] cnt, rld;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (pclk),
        .rst_n   (presetn),
        .async_i (ext_in),
        .level_o (ext_level),
        .rise_o  (ext_rise)
    );

    tmr_tick_sel u_tick (
        .run_i       (ctrl.run),
        .gate_sel_i  (ctrl.gate_sel),
        .edge_sel_i  (ctrl.edge_sel),
        .ext_level_i (ext_level),
        .ext_rise_i  (ext_rise),
        .tick_o      (tick)
    );

    tmr_counter #(.W(DATA_W)) u_cnt (
        .clk         (pclk),
        .rst_n       (presetn),
        .tick_i      (tick),
        .run_i       (run_next),
        .ctrl_wr_i   (ctrl_wr),
        .value_wr_i  (value_wr),
        .reload_wr_i (reload_wr),
        .wdata_i     (pwdata),
        .cnt_o       (cnt),
        .reload_o    (rld),
        .expire_o    (expire)
    );

    tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (pclk),
        .rst_n       (presetn),
        .psel        (psel),
        .penable     (penable),
        .pwrite      (pwrite),
        .paddr       (paddr),
        .pwdata_lo   (pwdata[3:0]),
        .cnt_i       (cnt),
        .rld_i       (rld),
        .expire_i    (expire),
        .ctrl_o      (ctrl),
        .run_o       (run_next),
        .ctrl_wr_o   (ctrl_wr),
        .value_wr_o  (value_wr),
        .reload_wr_o (reload_wr),
        .prdata_o    (prdata),
        .irq_o       (irq)
    );

    // R4 and R9: an enabled expiry always leaves the interrupt raised
    a_r4_expiry_raises_irq: assert property (@(posedge pclk) disable iff (!presetn)
        (expire && ctrl.irq_en) |=> irq);

    // R4: with interrupts masked a low line stays low
    a_r4_masked_stays_low: assert property (@(posedge pclk) disable iff (!presetn)
        (!irq && !ctrl.irq_en) |=> !irq);

    // R2: the control word never reads back upper bits
    a_r2_ctrl_upper_zero: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && paddr == '0) |-> (prdata[DATA_W-1:4] == '0));

endmodule

// File: tb/apb_reload_timer_test.sv
module apb_reload_timer_test;
    localparam int CLK_PERIOD = 100;
    localparam logic [11:0] A_CTRL = 12'h000;
    localparam logic [11:0] A_VAL  = 12'h004;
    localparam logic [11:0] A_RLD  = 12'h008;
    localparam logic [11:0] A_STS  = 12'h00C;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq;
    logic        ext_in = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) pclk = ~pclk;

    apb_reload_timer uut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .ext_in(ext_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one posedge: the write commits there; returns just after the next negedge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // zero-cycle read in the low phase
    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = a;
        #1;
        d = prdata;
        psel = 1'b0; penable = 1'b0;
        chk(req, d, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge pclk);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", A_CTRL, 32'h0);
        rd_chk("R1 value", A_VAL, 32'h0);
        rd_chk("R1 reload", A_RLD, 32'h0);
        rd_chk("R1 flag", A_STS, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 pready", {31'h0, pready}, 32'h1);
        chk("R1 pslverr", {31'h0, pslverr}, 32'h0);
    endtask

    task automatic t_ctrl_mask;
        wr(A_CTRL, 32'hFFFF_FFF8);
        rd_chk("R2 ctrl masked", A_CTRL, 32'h8);
        wr(A_CTRL, 32'h0000_0016);
        rd_chk("R2 ctrl low bits", A_CTRL, 32'h6);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_id;
        logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h22, 8'hB8,
                                    8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 12; i++)
            rd_chk("R10 id", 12'hFD0 + 12'(4*i), {24'h0, exp_id[i]});
        wr(12'hFD4, 32'hFFFF_FFFF);
        wr(12'hFE0, 32'h0);
        rd_chk("R10 id after write", 12'hFD4, 32'h0);
        rd_chk("R10 id after write", 12'hFE0, 32'h22);
    endtask

    task automatic t_unmapped;
        wr(A_CTRL, 32'h0);
        wr(A_RLD, 32'h33);
        rd_chk("R11 unmapped read", 12'h010, 32'h0);
        rd_chk("R11 unmapped read", 12'h800, 32'h0);
        rd_chk("R11 misaligned read", 12'h005, 32'h0);
        wr(12'h010, 32'hFFFF_FFFF);
        wr(12'h001, 32'hFFFF_FFFF);
        wr(12'h404, 32'h1234_5678);
        rd_chk("R11 ctrl kept", A_CTRL, 32'h0);
        rd_chk("R11 value kept", A_VAL, 32'h33);
        rd_chk("R11 reload kept", A_RLD, 32'h33);
    endtask

    task automatic t_disabled_and_step;
        wr(A_CTRL, 32'h0);
        wr(A_VAL, 32'd50);
        wait_cyc(5);
        rd_chk("R3 frozen when off", A_VAL, 32'd50);
        wr(A_CTRL, 32'h1);
        wait_cyc(4);
        rd_chk("R3 one per clock", A_VAL, 32'd46);
        wait_cyc(1);
        rd_chk("R3 one per clock", A_VAL, 32'd45);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_expiry_reload;
        wr(A_CTRL, 32'h0);
        wr(A_STS, 32'h1);
        wr(A_RLD, 32'd12);
        wr(A_CTRL, 32'h9);
        wr(A_VAL, 32'd5);
        wait_cyc(4);
        rd_chk("R5 one left", A_VAL, 32'd1);
        chk("R4 irq before expiry", {31'h0, irq}, 32'h0);
        wait_cyc(1);
        rd_chk("R5 at zero", A_VAL, 32'd0);
        rd_chk("R4 flag set", A_STS, 32'h1);
        chk("R4 irq level", {31'h0, irq}, 32'h1);
        wait_cyc(1);
        rd_chk("R5 reload taken", A_VAL, 32'd12);
        wait_cyc(1);
        rd_chk("R5 counting again", A_VAL, 32'd11);
        wr(A_CTRL, 32'h0);
        wr(A_STS, 32'h1);
        chk("R4 irq cleared", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_masked;
        wr(A_CTRL, 32'h0);
        wr(A_STS, 32'h1);
        wr(A_RLD, 32'h0);
        wr(A_CTRL, 32'h1);
        wr(A_VAL, 32'd2);
        wait_cyc(3);
        rd_chk("R4 masked count", A_VAL, 32'd0);
        rd_chk("R4 masked no flag", A_STS, 32'h0);
        chk("R4 masked irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_one_shot;
        wr(A_CTRL, 32'h0);
        wr(A_STS, 32'h1);
        wr(A_RLD, 32'h0);
        wr(A_CTRL, 32'h9);
        wr(A_VAL, 32'd4);
        wait_cyc(4);
        rd_chk("R6 expired", A_VAL, 32'd0);
        rd_chk("R6 flag once", A_STS, 32'h1);
        wr(A_STS, 32'h1);
        wait_cyc(10);
        rd_chk("R6 stays zero", A_VAL, 32'd0);
        rd_chk("R6 no second flag", A_STS, 32'h0);
    endtask

    task automatic t_reload_write;
        wr(A_RLD, 32'd7);
        rd_chk("R7 count loaded", A_VAL, 32'd7);
        rd_chk("R7 reload stored", A_RLD, 32'd7);
        wait_cyc(2);
        rd_chk("R7 resumes", A_VAL, 32'd5);
        wr(A_CTRL, 32'h0);
        wr(A_RLD, 32'd30);
        wait_cyc(3);
        rd_chk("R7 loaded while off", A_VAL, 32'd30);
    endtask

    task automatic t_value_write;
        wr(A_CTRL, 32'h0);
        wr(A_STS, 32'h1);
        wr(A_RLD, 32'h0);
        wr(A_CTRL, 32'h9);
        wr(A_VAL, 32'd20);
        wait_cyc(3);
        rd_chk("R8 restart", A_VAL, 32'd17);
        wr(A_VAL, 32'd0);
        wait_cyc(5);
        rd_chk("R8 stop at zero", A_VAL, 32'd0);
        wr(A_RLD, 32'd9);
        wr(A_VAL, 32'd0);
        rd_chk("R8 zero written", A_VAL, 32'd0);
        wait_cyc(1);
        rd_chk("R8 reload next tick", A_VAL, 32'd9);
        wait_cyc(1);
        rd_chk("R8 counting", A_VAL, 32'd8);
        rd_chk("R8 no flag", A_STS, 32'h0);
    endtask

    task automatic t_w1c;
        wr(A_CTRL, 32'h0);
        wr(A_STS, 32'h1);
        wr(A_RLD, 32'd100);
        wr(A_CTRL, 32'h9);
        wr(A_VAL, 32'd3);
        wait_cyc(2);
        wr(A_STS, 32'h1);            // commits on the 1-to-0 edge
        rd_chk("R9 set wins", A_STS, 32'h1);
        chk("R9 irq set wins", {31'h0, irq}, 32'h1);
        wr(A_STS, 32'h0);
        rd_chk("R9 zero write", A_STS, 32'h1);
        wr(A_STS, 32'hFFFF_FFFF);
        rd_chk("R9 cleared", A_STS, 32'h0);
        chk("R9 irq cleared", {31'h0, irq}, 32'h0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_gate;
        ext_in = 1'b0;
        wr(A_CTRL, 32'h0);
        wr(A_RLD, 32'd200);
        wr(A_CTRL, 32'h3);
        wait_cyc(5);
        rd_chk("R12 input low", A_VAL, 32'd200);
        ext_in = 1'b1;
        wait_cyc(10);
        rd_chk("R12 input high", A_VAL, 32'd192);
        ext_in = 1'b0;
        wait_cyc(6);
        rd_chk("R12 after fall", A_VAL, 32'd190);
        wait_cyc(4);
        rd_chk("R12 held", A_VAL, 32'd190);
    endtask

    task automatic t_edge;
        ext_in = 1'b0;
        wr(A_CTRL, 32'h0);
        wr(A_RLD, 32'd50);
        wr(A_CTRL, 32'h5);
        wait_cyc(3);
        rd_chk("R13 no edge", A_VAL, 32'd50);
        for (int i = 0; i < 3; i++) begin
            ext_in = 1'b1;
            wait_cyc(4);
            ext_in = 1'b0;
            wait_cyc(4);
        end
        rd_chk("R13 three edges", A_VAL, 32'd47);
        ext_in = 1'b1;
        wait_cyc(10);
        rd_chk("R13 long high", A_VAL, 32'd46);
        ext_in = 1'b0;
        wait_cyc(4);
        wr(A_CTRL, 32'h7);
        ext_in = 1'b1;
        wait_cyc(10);
        rd_chk("R13 edge over gate", A_VAL, 32'd45);
        ext_in = 1'b0;
        wait_cyc(4);
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge pclk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);
        t_reset();
        t_ctrl_mask();
        t_id();
        t_unmapped();
        t_disabled_and_step();
        t_expiry_reload();
        t_masked();
        t_one_shot();
        t_reload_write();
        t_value_write();
        t_w1c();
        t_gate();
        t_edge();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule